// File: doc/BRIEF.md
# Descriptor-List Register Capture Engine

This block is a hardware sequencer that runs a list of 32-bit descriptor words kept in a local SRAM. Each word's top two bits give its kind. An address word sets the target base, the direction and the bus path. A link word names one or two runs of target words to access. A loop word jumps back a number of words a set number of times. A read-modify-write word is followed by a mask word and a value word. A link word with every other bit clear ends the list.

The engine reads from, or writes to, target registers one word at a time over a request/acknowledge port. A path-select output stands in for the choice between the two system buses. Every word read from a target is appended to a capture region in the same SRAM, starting at a data base pointer.

Software writes the list into SRAM, sets the list base and data base (both word addresses) and a response timeout, then pulses start. It then watches for done and the two error flags.

Top module: `dlc_engine`

## Requirements
- R1: The engine decodes each list word by bits [31:30]. 2'b00 is an address word, 2'b01 a loop word, 2'b10 a read-modify-write word and 2'b11 a link word.
- R2: An address word sets the target base to bits [27:0] shifted left by 4. Bit 28 set selects write mode and clear selects read mode. Bit 29 drives `tgt_apb_o` for the accesses that follow.
- R3: A link word holds two runs, run A in bits [14:0] and run B in bits [29:15]. Each run is {count[6:0], offset[7:0]}. Run A starts at word index offset, counted from index 0 after the last address word. Run B starts at its offset plus the last word index covered by run A. A run with a count of zero is skipped. Word index w is accessed at byte address base + 4*w.
- R4: Each read result is written to consecutive SRAM words, starting at `data_base_i`.
- R5: A link word equal to 32'hC000_0000 ends the list. `busy_o` falls and `done_o` is high for exactly one cycle. `busy_o` rises in the cycle after `start_i` is sampled while idle.
- R6: In a loop word, bits [15:0] give how many words to step back from the loop word itself, and bits [27:16] give a repeat count N. With the default fixed shift, the body runs N+1 times in all.
- R7: In write mode, a link word is followed by a data word. That data is written once, to base + 4*(run A offset).
- R8: A read-modify-write word, its mask word M and its value word V write (R & ~M) | (V & M) back to the most recently read target address, where R is the data last read.
- R9: If a target access goes more than `timeout_i` cycles after its request without an acknowledge, the engine sets `bus_err_o`, stops the list and pulses `done_o`. An acknowledge in exactly cycle `timeout_i` is accepted.
- R10: When the data pointer reaches the top of the SRAM, `ovf_err_o` is set and further capture writes are dropped. The list keeps running.
- R11: After reset the engine is idle: busy, done, both error flags and both request outputs are low. Starting the engine clears the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| list_base_i | input | AW | Word address of the first list word |
| data_base_i | input | AW | Word address of the first capture slot |
| timeout_i | input | TO_W | Response timeout in cycles |
| busy_o | output | 1 | List is running |
| done_o | output | 1 | One-cycle pulse at end of list or abort |
| bus_err_o | output | 1 | Sticky response-timeout flag |
| ovf_err_o | output | 1 | Sticky capture-overflow flag |
| sram_req_o | output | 1 | SRAM access strobe |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | AW | SRAM word address |
| sram_wdata_o | output | 32 | SRAM write data |
| sram_rdata_i | input | 32 | SRAM read data, valid the cycle after a read |
| tgt_req_o | output | 1 | Target access request, held until acknowledge |
| tgt_we_o | output | 1 | Target write enable |
| tgt_apb_o | output | 1 | Bus path select for the access |
| tgt_addr_o | output | 32 | Target byte address |
| tgt_wdata_o | output | 32 | Target write data |
| tgt_ack_i | input | 1 | Target acknowledge |
| tgt_rdata_i | input | 32 | Target read data, valid with acknowledge |

## Verification
The bench targets run B's offset being relative to the end of run A. A design that took it from the base would capture the wrong register. It also runs a loop whose body must execute exactly N+1 times; an off-by-one repeat leaves one capture too many or too few, which shows in the slot after the last one. The timeout boundary is probed with an acknowledge in exactly the last allowed cycle and with one arriving a cycle late. A wrong comparison there either aborts a good access or accepts a late one. Capture near the top of the SRAM must stop and flag overflow rather than wrap over the list, and the read-modify-write must merge under the mask rather than write the raw value.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [1:0] {
    K_ADDR = 2'b00,
    K_LOOP = 2'b01,
    K_RMW  = 2'b10,
    K_LINK = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    PH_DESC,
    PH_WDATA,
    PH_MASK,
    PH_VALUE
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DECODE,
    S_PAIR,
    S_RD,
    S_STORE,
    S_WR
  } state_e;
endpackage

// File: rtl/dlc_decode.sv
module dlc_decode
  import dlc_pkg::*;
#(
  parameter int LOOP_SHIFT = 16
) (
  input  logic [31:0]            word_i,
  output kind_e                  kind_o,
  output logic [31:0]            base_o,
  output logic                   wr_o,
  output logic                   apb_o,
  output logic                   end_o,
  output logic [LOOP_SHIFT-1:0]  steps_o,
  output logic [27-LOOP_SHIFT:0] cnt_o
);
  assign kind_o  = kind_e'(word_i[31:30]);
  assign base_o  = {word_i[27:0], 4'b0000};
  assign wr_o    = word_i[28];
  assign apb_o   = word_i[29];
  assign end_o   = (word_i[31:30] == 2'b11) && (word_i[29:0] == '0);
  assign steps_o = word_i[LOOP_SHIFT-1:0];
  assign cnt_o   = word_i[27:LOOP_SHIFT];
endmodule

// File: rtl/dlc_watchdog.sv
module dlc_watchdog #(
  parameter int TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expired_o
);
  logic [TO_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i)               cnt_q <= '0;
    else if (cnt_q != '1)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dlc_engine.sv
module dlc_engine
  import dlc_pkg::*;
#(
  parameter int SRAM_WORDS = 256,
  parameter bit LOOP_FIXED = 1'b1,
  parameter int TO_W       = 16,
  parameter int CW         = 16,
  localparam int AW        = $clog2(SRAM_WORDS),
  localparam int LOOP_SHIFT = LOOP_FIXED ? 16 : AW,
  localparam int LCW       = 28 - LOOP_SHIFT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   list_base_i,
  input  logic [AW-1:0]   data_base_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            bus_err_o,
  output logic            ovf_err_o,
  output logic            sram_req_o,
  output logic            sram_we_o,
  output logic [AW-1:0]   sram_addr_o,
  output logic [31:0]     sram_wdata_o,
  input  logic [31:0]     sram_rdata_i,
  output logic            tgt_req_o,
  output logic            tgt_we_o,
  output logic            tgt_apb_o,
  output logic [31:0]     tgt_addr_o,
  output logic [31:0]     tgt_wdata_o,
  input  logic            tgt_ack_i,
  input  logic [31:0]     tgt_rdata_i
);
  localparam logic [AW:0] TOP = (AW+1)'(SRAM_WORDS);

  state_e state_q;
  phase_e phase_q;
  logic [AW-1:0]  ptr_q;
  logic [AW:0]    dptr_q;
  logic [31:0]    base_q, mask_q, wr_addr_q, wr_data_q, rd_q, last_addr_q, last_rd_q;
  logic           wr_q, apb_q, lact_q, bus_err_q, ovf_q, done_q;
  logic [29:0]    lnk_q;
  logic [1:0]     pi_q;
  logic [CW-1:0]  cw_q;
  logic [6:0]     rem_q;
  logic [LCW-1:0] lcnt_q;

  kind_e                 d_kind;
  logic [31:0]           d_base;
  logic                  d_wr, d_apb, d_end;
  logic [LOOP_SHIFT-1:0] d_steps;
  logic [LCW-1:0]        d_cnt, lrem;
  logic [14:0]           pair;
  logic [CW-1:0]         nxt_w;
  logic [31:0]           rd_addr;
  logic                  expired;

  dlc_decode #(.LOOP_SHIFT(LOOP_SHIFT)) i_dec (
    .word_i(sram_rdata_i), .kind_o(d_kind), .base_o(d_base), .wr_o(d_wr),
    .apb_o(d_apb), .end_o(d_end), .steps_o(d_steps), .cnt_o(d_cnt)
  );

  dlc_watchdog #(.TO_W(TO_W)) i_wdog (
    .clk_i, .rst_ni, .run_i(tgt_req_o && !tgt_ack_i), .limit_i(timeout_i), .expired_o(expired)
  );

  assign pair    = pi_q[0] ? lnk_q[29:15] : lnk_q[14:0];
  assign nxt_w   = cw_q + CW'(pair[7:0]);
  assign rd_addr = base_q + (32'(cw_q) << 2);
  assign lrem    = lact_q ? lcnt_q : d_cnt;

  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign bus_err_o    = bus_err_q;
  assign ovf_err_o    = ovf_q;
  assign sram_req_o   = (state_q == S_FETCH) || (state_q == S_STORE && dptr_q < TOP);
  assign sram_we_o    = (state_q == S_STORE);
  assign sram_addr_o  = (state_q == S_FETCH) ? ptr_q : dptr_q[AW-1:0];
  assign sram_wdata_o = rd_q;
  assign tgt_req_o    = (state_q == S_RD) || (state_q == S_WR);
  assign tgt_we_o     = (state_q == S_WR);
  assign tgt_apb_o    = apb_q;
  assign tgt_addr_o   = (state_q == S_WR) ? wr_addr_q : rd_addr;
  assign tgt_wdata_o  = wr_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;   phase_q <= PH_DESC;
      ptr_q <= '0;         dptr_q <= '0;
      base_q <= '0;        mask_q <= '0;      wr_addr_q <= '0;  wr_data_q <= '0;
      rd_q <= '0;          last_addr_q <= '0; last_rd_q <= '0;
      wr_q <= 1'b0;        apb_q <= 1'b0;     lact_q <= 1'b0;
      bus_err_q <= 1'b0;   ovf_q <= 1'b0;     done_q <= 1'b0;
      lnk_q <= '0;         pi_q <= '0;        cw_q <= '0;       rem_q <= '0;  lcnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          ptr_q     <= list_base_i;
          dptr_q    <= {1'b0, data_base_i};
          bus_err_q <= 1'b0;
          ovf_q     <= 1'b0;
          lact_q    <= 1'b0;
          cw_q      <= '0;
          phase_q   <= PH_DESC;
          state_q   <= S_FETCH;
        end
        S_FETCH: state_q <= S_DECODE;
        S_DECODE: begin
          state_q <= S_FETCH;
          ptr_q   <= ptr_q + 1'b1;
          unique case (phase_q)
            PH_DESC: unique case (d_kind)
              K_ADDR: begin
                base_q <= d_base; wr_q <= d_wr; apb_q <= d_apb; cw_q <= '0;
              end
              K_LINK: if (d_end) begin
                state_q <= S_IDLE;
                done_q  <= 1'b1;
              end else begin
                lnk_q   <= sram_rdata_i[29:0];
                pi_q    <= '0;
                state_q <= S_PAIR;
              end
              K_LOOP: if (lrem == '0) begin
                lact_q <= 1'b0;
              end else begin
                lact_q <= 1'b1;
                lcnt_q <= lrem - 1'b1;
                ptr_q  <= ptr_q - AW'(d_steps);
              end
              K_RMW: phase_q <= PH_MASK;
            endcase
            PH_MASK: begin
              mask_q  <= sram_rdata_i;
              phase_q <= PH_VALUE;
            end
            PH_VALUE: begin
              wr_addr_q <= last_addr_q;
              wr_data_q <= (last_rd_q & ~mask_q) | (sram_rdata_i & mask_q);
              phase_q   <= PH_DESC;
              state_q   <= S_WR;
            end
            PH_WDATA: begin
              wr_data_q <= sram_rdata_i;
              phase_q   <= PH_DESC;
              state_q   <= S_WR;
            end
          endcase
        end
        S_PAIR: begin
          if (pi_q == 2'd2) begin
            state_q <= S_FETCH;
          end else if (pair[14:8] == '0) begin
            pi_q <= pi_q + 1'b1;
          end else if (wr_q) begin
            // write mode: one word from run A, data word follows
            cw_q      <= nxt_w;
            wr_addr_q <= base_q + (32'(nxt_w) << 2);
            pi_q      <= 2'd2;
            phase_q   <= PH_WDATA;
            state_q   <= S_FETCH;
          end else begin
            cw_q    <= nxt_w;
            rem_q   <= pair[14:8];
            state_q <= S_RD;
          end
        end
        S_RD: begin
          if (tgt_ack_i) begin
            rd_q        <= tgt_rdata_i;
            last_rd_q   <= tgt_rdata_i;
            last_addr_q <= rd_addr;
            state_q     <= S_STORE;
          end else if (expired) begin
            bus_err_q <= 1'b1;
            done_q    <= 1'b1;
            state_q   <= S_IDLE;
          end
        end
        S_STORE: begin
          if (dptr_q < TOP) dptr_q <= dptr_q + 1'b1;
          else              ovf_q  <= 1'b1;
          if (rem_q > 7'd1) begin
            rem_q   <= rem_q - 1'b1;
            cw_q    <= cw_q + 1'b1;
            state_q <= S_RD;
          end else begin
            pi_q    <= pi_q + 1'b1;
            state_q <= S_PAIR;
          end
        end
        S_WR: begin
          if (tgt_ack_i) begin
            state_q <= S_FETCH;
          end else if (expired) begin
            bus_err_q <= 1'b1;
            done_q    <= 1'b1;
            state_q   <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tgt_req_o && !sram_req_o);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o && !tgt_ack_i && !expired |=> tgt_req_o && $stable(tgt_addr_o) && $stable(tgt_we_o));

  // R9
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_err_o) |-> done_o && !busy_o);

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o && busy_o |-> !(sram_req_o && sram_we_o));
endmodule

// File: tb/test_dlc_engine.sv
module test_dlc_engine;
  localparam int SW = 64;
  localparam int AW = 6;
  localparam logic [31:0] SENT = 32'h5A5A_5A5A;
  localparam logic [31:0] ENDW = 32'hC000_0000;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [AW-1:0] lb = '0, db = '0;
  logic [15:0] tmo = 16'd8;
  logic busy, done, berr, ovf;
  logic sreq, swe;
  logic [AW-1:0] saddr;
  logic [31:0] swdata, srdata;
  logic treq, twe, tapb, tack;
  logic [31:0] taddr, twdata, trdata;

  logic [31:0] mem [SW];
  logic [31:0] regs [64];
  int dly = 1, wcnt = 0, nacc = 0;
  logic last_apb = 1'b0;
  int checks = 0, fails = 0;

  always #4ns clk = ~clk;

  dlc_engine #(.SRAM_WORDS(SW)) i_dlc_engine (
    .clk_i(clk), .rst_ni, .start_i(start), .list_base_i(lb), .data_base_i(db),
    .timeout_i(tmo), .busy_o(busy), .done_o(done), .bus_err_o(berr), .ovf_err_o(ovf),
    .sram_req_o(sreq), .sram_we_o(swe), .sram_addr_o(saddr), .sram_wdata_o(swdata),
    .sram_rdata_i(srdata), .tgt_req_o(treq), .tgt_we_o(twe), .tgt_apb_o(tapb),
    .tgt_addr_o(taddr), .tgt_wdata_o(twdata), .tgt_ack_i(tack), .tgt_rdata_i(trdata)
  );

  initial begin srdata = '0; tack = 1'b0; trdata = '0; end

  always @(posedge clk) begin
    if (sreq && swe)  mem[saddr] <= swdata;
    if (sreq && !swe) srdata <= mem[saddr];
    if (treq && !tack) wcnt <= wcnt + 1; else wcnt <= 0;
    if (treq && tack) begin
      nacc <= nacc + 1;
      last_apb <= tapb;
      if (twe) regs[taddr[7:2]] <= twdata;
    end
  end

  always @(negedge clk) begin
    tack   = treq && (wcnt == dly);
    trdata = regs[taddr[7:2]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic prep();
    for (int i = 0; i < SW; i++) mem[i] = SENT;
    for (int i = 0; i < 64; i++) regs[i] = 32'hA000_0000 + i;
    nacc = 0;
  endtask

  task automatic run(input logic [AW-1:0] l, input logic [AW-1:0] d);
    int n = 0;
    @(negedge clk); lb = l; db = d; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R11 busy after start", 32'(busy), 1);
    while (!done && n < 4000) begin @(negedge clk); n++; end
    check("R5 done reached", 32'(done), 1);
    check("R5 busy low at done", 32'(busy), 0);
    @(negedge clk);
    check("R5 done one cycle", 32'(done), 0);
  endtask

  task automatic t_reset();
    check("R11 busy", 32'(busy), 0);
    check("R11 done", 32'(done), 0);
    check("R11 errs", {30'd0, berr, ovf}, 0);
    check("R11 reqs", {30'd0, treq, sreq}, 0);
  endtask

  task automatic t_pairs();
    prep();
    mem[0] = 32'h0000_0100;
    mem[1] = ENDW | (32'h102 << 15) | 32'h201;
    mem[2] = ENDW;
    run(6'd0, 6'd32);
    check("R1 R3 R4 run A word1", mem[32], 32'hA000_0001);
    check("R3 R4 run A word2", mem[33], 32'hA000_0002);
    check("R3 run B relative", mem[34], 32'hA000_0004);
    check("R4 no extra slot", mem[35], SENT);
    check("R3 access count", 32'(nacc), 3);
    check("R2 ahb path", 32'(last_apb), 0);
  endtask

  task automatic t_write();
    prep();
    mem[0] = 32'h3000_0100;
    mem[1] = 32'hC000_8103;
    mem[2] = 32'hDEAD_BEEF;
    mem[3] = ENDW;
    run(6'd0, 6'd32);
    check("R7 write data", regs[3], 32'hDEAD_BEEF);
    check("R2 apb path", 32'(last_apb), 1);
    check("R7 one access", 32'(nacc), 1);
    check("R7 nothing captured", mem[32], SENT);
  endtask

  task automatic t_loop();
    prep();
    mem[0] = 32'h0000_0100;
    mem[1] = 32'hC000_0105;
    mem[2] = 32'h4002_0002;
    mem[3] = ENDW;
    run(6'd0, 6'd40);
    check("R6 pass1", mem[40], 32'hA000_0005);
    check("R6 pass2", mem[41], 32'hA000_0005);
    check("R6 pass3", mem[42], 32'hA000_0005);
    check("R6 no fourth pass", mem[43], SENT);
    check("R6 read count", 32'(nacc), 3);
  endtask

  task automatic t_rmw();
    prep();
    regs[6] = 32'hAABB_CCDD;
    mem[0] = 32'h0000_0100;
    mem[1] = 32'hC000_0106;
    mem[2] = 32'h8000_0000;
    mem[3] = 32'h0000_FF00;
    mem[4] = 32'h1234_5678;
    mem[5] = ENDW;
    run(6'd0, 6'd32);
    check("R8 captured before", mem[32], 32'hAABB_CCDD);
    check("R8 merged write", regs[6], 32'hAABB_56DD);
  endtask

  task automatic t_timeout();
    prep();
    tmo = 16'd4; dly = 4;
    mem[0] = 32'h0000_0100;
    mem[1] = 32'hC000_0107;
    mem[2] = ENDW;
    run(6'd0, 6'd20);
    check("R9 ack at limit accepted", mem[20], 32'hA000_0007);
    check("R9 no error at limit", 32'(berr), 0);
    prep();
    mem[0] = 32'h0000_0100;
    mem[1] = 32'hC000_0107;
    mem[2] = ENDW;
    dly = 5;
    run(6'd0, 6'd20);
    check("R9 late ack aborts", 32'(berr), 1);
    check("R9 no capture on abort", mem[20], SENT);
    dly = 1; tmo = 16'd8;
    prep();
    mem[0] = 32'h0000_0100;
    mem[1] = 32'hC000_0101;
    mem[2] = ENDW;
    run(6'd0, 6'd20);
    check("R11 start clears error", 32'(berr), 0);
  endtask

  task automatic t_overflow();
    prep();
    mem[0] = 32'h0000_0100;
    mem[1] = 32'hC000_0300;
    mem[2] = ENDW;
    run(6'd0, 6'd62);
    check("R10 slot 62", mem[62], 32'hA000_0000);
    check("R10 slot 63", mem[63], 32'hA000_0001);
    check("R10 flag set", 32'(ovf), 1);
    check("R10 no wrap", mem[0], 32'h0000_0100);
    check("R10 list kept running", 32'(nacc), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_pairs();
    t_write();
    t_loop();
    t_rmw();
    t_timeout();
    t_overflow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule